// File: doc/BRIEF.md
# Display Configuration and Shutdown Controller

This block owns the 8-bit configuration register of a multiplexed display controller and sequences the power state of the display scan. The register carries the run/shutdown select, a configuration lock, the blink-rate select, the display-mode select and two action bits that fire a one-shot clear of the segment memories and a one-shot restart of blink timing and scan. On a read the top bit returns the live blink phase instead of stored data.

Shutdown is not immediate. When the run bit is cleared, the multiplex oscillator keeps running until the scan sequencer reports the end of the period in progress; only then does it stop, the blanking output go high and the pump and filament outputs get held low. On wake-up the oscillator restarts at once, but blanking stays high until the sequencer reports the end of a full multiplex cycle, so stale data in the external tube driver never reaches the display. A display-test flag overrides shutdown. The lock bit masks forwarded writes to a parameterised list of layout registers while leaving every other address, including the map pointer, writable.

Top module: `disp_cfg_ctrl`

## Requirements
- R1: After reset the oscillator run enable is 0, blanking is 1, the drive hold is 1, lock, blink-rate and mode outputs are 0, and readback bits 6..0 are 0.
- R2: A write to the configuration address stores bit 0 as run select (1 = run), bit 1 as lock, bit 2 as blink-rate select, bit 3 as a spare readable bit and bit 6 as mode select; the lock, blink-rate and mode outputs follow from the cycle after the write.
- R3: Readback returns bit 7 equal to the blink-phase input at that moment and bits 5 and 4 as 0.
- R4: Writing bit 5 as 1 produces a clear pulse, and writing bit 4 as 1 produces a resync pulse, each high for exactly the one cycle after the write; neither bit is stored.
- R5: With run select 0 and display test off, the oscillator keeps running until an end-of-period strobe; in the cycle after that strobe the run enable is 0, blanking is 1 and the drive hold is 1.
- R6: On leaving shutdown the run enable returns to 1 one cycle after the state change is requested, blanking stays 1 until an end-of-cycle strobe, and is 0 from the cycle after that strobe.
- R7: Display test high forces the oscillator to run from the next cycle whatever the run select, with the same blanking rule as R6 when leaving the halted state.
- R8: While locked, writes to the grids (0x03), shift-limit (0x0E) and map-data (0x06) addresses are not forwarded; writes to any other address except the configuration address (0x04), including the map pointer (0x05), are forwarded; configuration writes are never forwarded.
- R9: Restoring run select before the end-of-period strobe cancels shutdown with no blanking.
- R10: Stored configuration bits are kept through shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register write address |
| wdata_i | input | 8 | Register write data |
| period_end_i | input | 1 | End of current multiplex period strobe |
| cycle_end_i | input | 1 | End of multiplex cycle strobe |
| disp_test_i | input | 1 | Display test active |
| blink_phase_i | input | 1 | Blink phase level for readback |
| cfg_rdata_o | output | 8 | Configuration readback |
| wr_fwd_o | output | 1 | Write passed on to downstream registers |
| osc_run_o | output | 1 | Multiplex oscillator run enable |
| blank_o | output | 1 | Tube driver blanking, high = blanked |
| drive_hold_o | output | 1 | Hold pump and filament outputs low |
| cfg_lock_o | output | 1 | Configuration lock flag |
| blink_fast_o | output | 1 | Blink-rate select |
| mode_wide_o | output | 1 | Display-mode select |
| resync_o | output | 1 | One-shot blink and scan restart |
| clear_o | output | 1 | One-shot segment memory clear |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, the configuration register at 0x04, and a three-entry lock list of 0x03, 0x0E and 0x06 with the map pointer at 0x05 left open. That reaches every power-state transition, including a shutdown cancelled in flight and display test pulling the scan out of the halted state, and lets each locked address, the open pointer and an unrelated address be probed through the forward strobe with the lock set and cleared.

// File: rtl/disp_cfg_pkg.sv
package disp_cfg_pkg;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_LOCK  = 1;
  localparam int unsigned B_RATE  = 2;
  localparam int unsigned B_SPARE = 3;
  localparam int unsigned B_SYNC  = 4;
  localparam int unsigned B_CLR   = 5;
  localparam int unsigned B_MODE  = 6;
  localparam int unsigned B_PHASE = 7;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_RUN  = 2'd2,
    PS_STOP = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/cfg_reg.sv
module cfg_reg
  import disp_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             blink_phase_i,
  output logic             run_sel_o,
  output logic             lock_o,
  output logic             rate_o,
  output logic             mode_o,
  output logic             clear_o,
  output logic             resync_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic run_q, lock_q, rate_q, spare_q, mode_q, clr_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      lock_q  <= 1'b0;
      rate_q  <= 1'b0;
      spare_q <= 1'b0;
      mode_q  <= 1'b0;
      clr_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      clr_q  <= we_i & wdata_i[B_CLR];
      sync_q <= we_i & wdata_i[B_SYNC];
      if (we_i) begin
        run_q   <= wdata_i[B_RUN];
        lock_q  <= wdata_i[B_LOCK];
        rate_q  <= wdata_i[B_RATE];
        spare_q <= wdata_i[B_SPARE];
        mode_q  <= wdata_i[B_MODE];
      end
    end
  end

  assign run_sel_o = run_q;
  assign lock_o    = lock_q;
  assign rate_o    = rate_q;
  assign mode_o    = mode_q;
  assign clear_o   = clr_q;
  assign resync_o  = sync_q;
  // action bits read as zero; top bit is live phase
  assign rdata_o = {blink_phase_i, mode_q, 1'b0, 1'b0, spare_q, rate_q, lock_q, run_q};

  p_clear_one_shot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);
  p_sync_one_shot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o);
  p_hold_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o[6:0]));
endmodule

// File: rtl/lock_gate.sv
module lock_gate #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_LOCKED = 3,
  parameter logic [N_LOCKED*ADDR_W-1:0] LOCKED_LIST = {8'h03, 8'h0E, 8'h06},
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h04
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_i,
  output logic              cfg_we_o,
  output logic              wr_fwd_o
);
  logic [N_LOCKED-1:0] hit;

  for (genvar g = 0; g < N_LOCKED; g++) begin : g_hit
    assign hit[g] = (addr_i == LOCKED_LIST[g*ADDR_W +: ADDR_W]);
  end

  logic is_cfg;
  assign is_cfg   = (addr_i == CFG_ADDR);
  assign cfg_we_o = wr_i & is_cfg;
  assign wr_fwd_o = wr_i & ~is_cfg & ~(lock_i & |hit);

  always_comb begin
    a_fwd_excl_r8: assert (!(cfg_we_o && wr_fwd_o));
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import disp_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_sel_i,
  input  logic disp_test_i,
  input  logic period_end_i,
  input  logic cycle_end_i,
  output logic osc_run_o,
  output logic blank_o,
  output logic drive_hold_o
);
  pwr_state_e state_q, state_d;
  logic blank_q, blank_d, sd_req;

  assign sd_req = ~run_sel_i & ~disp_test_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF:  if (!sd_req) state_d = PS_WAKE;
      PS_WAKE: if (sd_req) state_d = PS_STOP;
               else if (cycle_end_i) state_d = PS_RUN;
      PS_RUN:  if (sd_req) state_d = PS_STOP;
      PS_STOP: if (!sd_req) state_d = blank_q ? PS_WAKE : PS_RUN;
               else if (period_end_i) state_d = PS_OFF;
      default: state_d = PS_OFF;
    endcase
  end

  always_comb begin
    blank_d = blank_q;
    if (state_d == PS_OFF) blank_d = 1'b1;
    else if (state_d == PS_RUN) blank_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_OFF;
      blank_q <= 1'b1;
    end else begin
      state_q <= state_d;
      blank_q <= blank_d;
    end
  end

  assign osc_run_o    = (state_q != PS_OFF);
  assign drive_hold_o = (state_q == PS_OFF);
  assign blank_o      = blank_q;

  p_halt_at_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_run_o) |-> $past(period_end_i));
  p_halt_blanks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_o |-> blank_o && drive_hold_o);
  p_unblank_on_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> $past(cycle_end_i));
  p_test_runs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_test_i |=> osc_run_o);
endmodule

// File: rtl/disp_cfg_ctrl.sv
module disp_cfg_ctrl
  import disp_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_LOCKED = 3,
  parameter logic [N_LOCKED*ADDR_W-1:0] LOCKED_LIST = {8'h03, 8'h0E, 8'h06},
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              period_end_i,
  input  logic              cycle_end_i,
  input  logic              disp_test_i,
  input  logic              blink_phase_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  output logic              wr_fwd_o,
  output logic              osc_run_o,
  output logic              blank_o,
  output logic              drive_hold_o,
  output logic              cfg_lock_o,
  output logic              blink_fast_o,
  output logic              mode_wide_o,
  output logic              resync_o,
  output logic              clear_o
);
  logic cfg_we, run_sel;

  lock_gate #(
    .ADDR_W(ADDR_W), .N_LOCKED(N_LOCKED),
    .LOCKED_LIST(LOCKED_LIST), .CFG_ADDR(CFG_ADDR)
  ) u_gate (
    .wr_i(wr_i), .addr_i(addr_i), .lock_i(cfg_lock_o),
    .cfg_we_o(cfg_we), .wr_fwd_o(wr_fwd_o)
  );

  cfg_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we), .wdata_i(wdata_i),
    .blink_phase_i(blink_phase_i), .run_sel_o(run_sel), .lock_o(cfg_lock_o),
    .rate_o(blink_fast_o), .mode_o(mode_wide_o), .clear_o(clear_o),
    .resync_o(resync_o), .rdata_o(cfg_rdata_o)
  );

  pwr_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_sel_i(run_sel),
    .disp_test_i(disp_test_i), .period_end_i(period_end_i),
    .cycle_end_i(cycle_end_i), .osc_run_o(osc_run_o), .blank_o(blank_o),
    .drive_hold_o(drive_hold_o)
  );

  p_lock_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CFG_ADDR) |=> cfg_lock_o == $past(wdata_i[B_LOCK]));
endmodule

// File: tb/disp_cfg_ctrl_bench.sv
module disp_cfg_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, pend = 1'b0, cend = 1'b0, test = 1'b0, phase = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic fwd, osc, blank, hold, lock, rate, mode, sync, clr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_cfg_ctrl u_disp_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .period_end_i(pend), .cycle_end_i(cend), .disp_test_i(test),
    .blink_phase_i(phase), .cfg_rdata_o(rdata), .wr_fwd_o(fwd),
    .osc_run_o(osc), .blank_o(blank), .drive_hold_o(hold),
    .cfg_lock_o(lock), .blink_fast_o(rate), .mode_wide_o(mode),
    .resync_o(sync), .clear_o(clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] d);
    wr = 1'b1; addr = 8'h04; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 osc", osc, 0); chk("R1 blank", blank, 1); chk("R1 hold", hold, 1);
    chk("R1 lock", lock, 0); chk("R1 rate", rate, 0); chk("R1 mode", mode, 0);
    chk("R1 rdata", rdata[6:0], 0);
  endtask

  task automatic t_fields();
    cfg_write(8'h4E);
    chk("R2 mode", mode, 1); chk("R2 rate", rate, 1); chk("R2 lock", lock, 1);
    chk("R3 rdata phase0", rdata, 8'h4E);
    phase = 1'b1; #1;
    chk("R3 rdata phase1", rdata, 8'hCE);
    phase = 1'b0;
    cfg_write(8'h00);
    chk("R2 cleared", rdata, 8'h00);
  endtask

  task automatic t_pulses();
    cfg_write(8'h20);
    chk("R4 clear hi", clr, 1); chk("R4 no sync", sync, 0);
    chk("R4 clr bit reads 0", rdata[5], 0);
    step();
    chk("R4 clear lo", clr, 0);
    cfg_write(8'h10);
    chk("R4 sync hi", sync, 1); chk("R4 no clear", clr, 0);
    chk("R4 sync bit reads 0", rdata[4], 0);
    step();
    chk("R4 sync lo", sync, 0);
  endtask

  task automatic t_wake();
    cfg_write(8'h01);
    chk("R6 still off", osc, 0);
    step();
    chk("R6 osc on", osc, 1); chk("R6 blank held", blank, 1); chk("R6 hold off", hold, 0);
    repeat (3) step();
    chk("R6 blank until cycle", blank, 1);
    strobe(cend);
    chk("R6 unblank", blank, 0); chk("R6 osc", osc, 1);
  endtask

  task automatic t_shutdown();
    cfg_write(8'h44);
    step();
    repeat (3) step();
    chk("R5 osc until period", osc, 1); chk("R5 not blank yet", blank, 0);
    strobe(pend);
    chk("R5 osc off", osc, 0); chk("R5 blank", blank, 1); chk("R5 hold", hold, 1);
    repeat (2) step();
    chk("R10 retained", rdata[6:0], 7'h44);
    chk("R10 mode kept", mode, 1);
  endtask

  task automatic t_cancel();
    cfg_write(8'h01); step(); strobe(cend);
    chk("R9 running", blank, 0);
    cfg_write(8'h00); step();
    chk("R9 stopping osc", osc, 1);
    cfg_write(8'h01);
    chk("R9 no blank", blank, 0);
    step();
    chk("R9 osc", osc, 1); chk("R9 still unblank", blank, 0);
    strobe(pend);
    chk("R9 period ignored", osc, 1);
  endtask

  task automatic t_test();
    cfg_write(8'h00); step(); strobe(pend);
    chk("R7 off first", osc, 0);
    test = 1'b1; step();
    chk("R7 test runs", osc, 1); chk("R7 test blank", blank, 1);
    strobe(cend);
    chk("R7 test unblank", blank, 0);
    test = 1'b0; step();
    chk("R7 stop pending", osc, 1);
    strobe(pend);
    chk("R7 halted", osc, 0);
  endtask

  task automatic probe(input string req, input logic [7:0] a, input int exp);
    wr = 1'b1; addr = a; wdata = 8'h00; #1;
    chk(req, fwd, exp);
    step(); wr = 1'b0;
  endtask

  task automatic t_lock();
    cfg_write(8'h02);
    probe("R8 grids", 8'h03, 0); probe("R8 shift", 8'h0E, 0);
    probe("R8 map data", 8'h06, 0); probe("R8 map ptr", 8'h05, 1);
    probe("R8 other", 8'h20, 1);
    wr = 1'b1; addr = 8'h04; wdata = 8'h02; #1;
    chk("R8 cfg never fwd", fwd, 0);
    step(); wr = 1'b0;
    cfg_write(8'h00);
    probe("R8 unlocked grids", 8'h03, 1);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_fields(); t_pulses(); t_wake(); t_shutdown();
    t_cancel(); t_test(); t_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule